// File: doc/BRIEF.md
# Way-Predicted Set-Associative Tag Lookup

This block is the lookup controller of a set-associative cache that keeps a guessed way for every set. When an access arrives, the block reads the guessed way for the addressed set. That guess steers the data multiplexer at once and picks the single tag that is compared in the first cycle. If the guess is right, the hit is reported on the next clock edge. If it is wrong, the controller holds the access for one more cycle. In that cycle it compares the remaining ways, reports either a hit or a miss, and rewrites the guess for the set.

The tag and valid arrays sit in flip-flops inside the block. On a miss the controller allocates a way and installs the new tag, so that later accesses to the same line hit. The chosen way is the lowest invalid way, or a rotating pointer once the set is full. Moving the line's data is left to the surrounding cache. The block only reports which way the data multiplexer should select.

Top module: `wp_lookup`

## Requirements
- R1: After reset no way of any set is valid, every set's guessed way is 0, `req_ready` is 1, `busy` is 0, and `rsp_valid` is 0. The first access to any line therefore misses and is placed in way 0.
- R2: An address splits into three fields. Bits [OFFSET_W-1:0] are the byte offset and take no part in the lookup. The next IDX_W bits select the set. The remaining upper bits form the tag. Two addresses that differ only in the offset refer to the same line.
- R3: Suppose an access is accepted and its line is valid in the guessed way of its set. Then `rsp_valid`, `rsp_hit` and `rsp_way` (equal to the guessed way) appear in the cycle after acceptance, with `rsp_slow` = 0, and `busy` is never raised.
- R4: Suppose the line is held in a way other than the guessed one. Then `busy` is 1 and `req_ready` is 0 for exactly the cycle after acceptance, and `data_sel` shows the matching way in that cycle. The hit is reported one cycle later with `rsp_slow` = 1 and `rsp_way` equal to the matching way.
- R5: After a hit that takes two cycles, the set's guess names the way that hit, so the next access to that line completes in one cycle.
- R6: When no way of the set holds the tag, a miss is reported in the second cycle with `rsp_slow` = 1. Exactly one of `rsp_hit` and `rsp_miss` is set while `rsp_valid` is 1. The tag is installed in the lowest-numbered invalid way, which becomes the set's guess and is returned on `rsp_way`.
- R7: A miss to a set whose ways are all valid replaces the way named by one rotating pointer shared by all sets. The pointer starts at 0 and advances by one, modulo WAYS, after each such replacement.
- R8: While `busy` is 1 a request is not accepted and produces no response. `rsp_hit` and `rsp_miss` are 0 whenever `rsp_valid` is 0.
- R9: In the cycle an access is presented, `data_sel` equals the guessed way of the addressed set, before any tag compare resolves.
- R10: Sets are independent. Fills and guess updates in one set leave every other set's contents and guess unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | ADDR_W | Byte address of the access |
| req_ready | output | 1 | Controller can accept a request this cycle |
| busy | output | 1 | Second lookup cycle in progress |
| data_sel | output | log2(WAYS) | Way steering the data multiplexer this cycle |
| rsp_valid | output | 1 | One-cycle pulse: result of an access |
| rsp_hit | output | 1 | Result is a hit |
| rsp_miss | output | 1 | Result is a miss (tag installed) |
| rsp_way | output | log2(WAYS) | Way that hit, or way allocated on a miss |
| rsp_slow | output | 1 | Result took two cycles |

## Verification
The case that is hardest to reach from the ports is a hit in a way other than the guessed one. It needs a set that holds several valid lines, with the guess pointing at a different line than the one addressed. The bench first fills every set past its capacity, which also drives the rotating replacement pointer. It then revisits lines in an order other than the fill order, and repeats each access with a changed offset. Finally it runs a long pseudo-random run over six tags per set to mix fast hits, slow hits and full-set replacements. A model in the bench predicts the latency and way of every access and also checks that a request made during the busy cycle is dropped.

// File: rtl/wp_pkg.sv
package wp_pkg;

   typedef enum logic {
      WP_FIRST  = 1'b0,
      WP_SECOND = 1'b1
   } wp_state_e;

   localparam int WP_VICTIM_ROTATE     = 0;
   localparam int WP_VICTIM_AFTER_PRED = 1;

endpackage

// File: rtl/wp_tag_store.sv
module wp_tag_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int TAG_W = 8,
   parameter int IDX_W = $clog2(SETS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [IDX_W-1:0]               rd_set,
   output logic [WAYS-1:0][TAG_W-1:0]     rd_tags,
   output logic [WAYS-1:0]                rd_valid,
   input  logic                           wr_en,
   input  logic [IDX_W-1:0]               wr_set,
   input  logic [WAY_W-1:0]               wr_way,
   input  logic [TAG_W-1:0]               wr_tag
);

   logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag_q;
   logic [SETS-1:0][WAYS-1:0]            val_q;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic hit_wr;
         assign hit_wr = wr_en && (wr_set == IDX_W'(s)) && (wr_way == WAY_W'(w));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q[s][w] <= '0;
               val_q[s][w] <= 1'b0;
            end else if (hit_wr) begin
               tag_q[s][w] <= wr_tag;
               val_q[s][w] <= 1'b1;
            end
         end
      end
   end

   assign rd_tags  = tag_q[rd_set];
   assign rd_valid = val_q[rd_set];

   AST_FILL_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (rd_set == wr_set) |=> rd_valid != '0 || rd_set != $past(wr_set)) else $error("fill lost"); // R6

endmodule

// File: rtl/wp_pred_table.sv
module wp_pred_table #(
   parameter int SETS  = 4,
   parameter int WAYS  = 4,
   parameter int IDX_W = $clog2(SETS),
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_set,
   output logic [WAY_W-1:0] rd_way,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way
);

   logic [SETS-1:0][WAY_W-1:0] guess_q;

   for (genvar s = 0; s < SETS; s++) begin : g_set
      always_ff @(posedge clk) begin
         if (!rst_n)
            guess_q[s] <= '0;
         else if (wr_en && (wr_set == IDX_W'(s)))
            guess_q[s] <= wr_way;
      end
   end

   assign rd_way = guess_q[rd_set];

   AST_GUESS_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> guess_q[$past(wr_set)] == $past(wr_way)) else $error("guess not stored"); // R5

endmodule

// File: rtl/wp_victim.sv
module wp_victim #(
   parameter int WAYS  = 4,
   parameter int MODE  = 0,
   parameter int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WAYS-1:0]  valid,
   input  logic [WAY_W-1:0] pred_way,
   input  logic             take,
   output logic [WAY_W-1:0] victim
);

   logic             full;
   logic [WAY_W-1:0] first_free;
   logic [WAY_W-1:0] fallback;

   assign full = &valid;

   always_comb begin
      first_free = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!valid[i]) first_free = WAY_W'(i);
      end
   end

   if (MODE == 0) begin : g_rotate
      logic [WAY_W-1:0] ptr_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            ptr_q <= '0;
         else if (take && full)
            ptr_q <= ptr_q + 1'b1;
      end
      assign fallback = ptr_q;
   end else begin : g_after_pred
      assign fallback = pred_way + 1'b1;
   end

   assign victim = full ? fallback : first_free;

   AST_VICTIM_IS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      take && !full |-> !valid[victim]) else $error("victim valid"); // R6

endmodule

// File: rtl/wp_lookup.sv
module wp_lookup
   import wp_pkg::*;
#(
   parameter int ADDR_W      = 12,
   parameter int OFFSET_W    = 2,
   parameter int SETS        = 4,
   parameter int WAYS        = 4,
   parameter int VICTIM_MODE = WP_VICTIM_ROTATE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_valid,
   input  logic [ADDR_W-1:0]          req_addr,
   output logic                       req_ready,
   output logic                       busy,
   output logic [$clog2(WAYS)-1:0]    data_sel,
   output logic                       rsp_valid,
   output logic                       rsp_hit,
   output logic                       rsp_miss,
   output logic [$clog2(WAYS)-1:0]    rsp_way,
   output logic                       rsp_slow
);

   localparam int IDX_W = $clog2(SETS);
   localparam int WAY_W = $clog2(WAYS);
   localparam int TAG_W = ADDR_W - OFFSET_W - IDX_W;

   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W leaves no tag bits");
   end
   if (VICTIM_MODE != WP_VICTIM_ROTATE && VICTIM_MODE != WP_VICTIM_AFTER_PRED) begin : g_bad_mode
      $error("unknown VICTIM_MODE");
   end

   wp_state_e              state_q;
   logic [IDX_W-1:0]       held_set;
   logic [TAG_W-1:0]       held_tag;
   logic [WAY_W-1:0]       held_pred;

   logic [IDX_W-1:0]       req_set;
   logic [TAG_W-1:0]       req_tag;
   logic                   in_second;
   logic [IDX_W-1:0]       rd_set;
   logic [WAY_W-1:0]       pred_way;
   logic [WAYS-1:0][TAG_W-1:0] st_tags;
   logic [WAYS-1:0]        st_valid;
   logic                   accept;
   logic [TAG_W-1:0]       pred_tag;
   logic                   fast_hit;
   logic [WAYS-1:0]        other_match;
   logic                   hit2;
   logic [WAY_W-1:0]       hit_way;
   logic [WAY_W-1:0]       victim_way;
   logic [WAY_W-1:0]       fill_way;
   logic                   do_fill;

   assign req_set   = req_addr[OFFSET_W +: IDX_W];
   assign req_tag   = req_addr[ADDR_W-1 -: TAG_W];
   assign in_second = (state_q == WP_SECOND);
   assign rd_set    = in_second ? held_set : req_set;
   assign accept    = req_valid && !in_second;

   wp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_set   (rd_set),
      .rd_tags  (st_tags),
      .rd_valid (st_valid),
      .wr_en    (do_fill),
      .wr_set   (held_set),
      .wr_way   (victim_way),
      .wr_tag   (held_tag)
   );

   wp_pred_table #(.SETS(SETS), .WAYS(WAYS)) u_pred (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_set (rd_set),
      .rd_way (pred_way),
      .wr_en  (in_second),
      .wr_set (held_set),
      .wr_way (fill_way)
   );

   wp_victim #(.WAYS(WAYS), .MODE(VICTIM_MODE)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (st_valid),
      .pred_way (held_pred),
      .take     (do_fill),
      .victim   (victim_way)
   );

   // first cycle: one tag, the guessed way only
   assign pred_tag = st_tags[pred_way];
   assign fast_hit = st_valid[pred_way] && (pred_tag == req_tag);

   // second cycle: the remaining ways in parallel
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign other_match[w] = st_valid[w] && (st_tags[w] == held_tag) &&
                              (held_pred != WAY_W'(w));
   end

   assign hit2 = |other_match;

   always_comb begin
      hit_way = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (other_match[i]) hit_way = WAY_W'(i);
      end
   end

   assign do_fill  = in_second && !hit2;
   assign fill_way = hit2 ? hit_way : victim_way;
   assign data_sel = in_second ? fill_way : pred_way;
   assign busy      = in_second;
   assign req_ready = !in_second;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= WP_FIRST;
         held_set  <= '0;
         held_tag  <= '0;
         held_pred <= '0;
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_way   <= '0;
         rsp_slow  <= 1'b0;
      end else begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         case (state_q)
            WP_FIRST: begin
               if (accept) begin
                  if (fast_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_hit   <= 1'b1;
                     rsp_way   <= pred_way;
                     rsp_slow  <= 1'b0;
                  end else begin
                     state_q   <= WP_SECOND;
                     held_set  <= req_set;
                     held_tag  <= req_tag;
                     held_pred <= pred_way;
                  end
               end
            end
            WP_SECOND: begin
               rsp_valid <= 1'b1;
               rsp_hit   <= hit2;
               rsp_miss  <= !hit2;
               rsp_way   <= fill_way;
               rsp_slow  <= 1'b1;
               state_q   <= WP_FIRST;
            end
            default: state_q <= WP_FIRST;
         endcase
      end
   end

   AST_BUSY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy) else $error("busy too long"); // R4
   AST_SLOW_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> rsp_valid && rsp_slow) else $error("no slow result"); // R4
   AST_ACCEPT_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid ^ busy) else $error("accept lost"); // R3
   AST_FAST_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_slow |-> !$past(busy)) else $error("fast after busy"); // R3
   AST_MISS_IS_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_miss |-> rsp_slow) else $error("fast miss"); // R6
   AST_HIT_XOR_MISS: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_hit ^ rsp_miss) else $error("hit and miss"); // R6
   AST_QUIET_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !rsp_hit && !rsp_miss) else $error("stray flag"); // R8

endmodule

// File: tb/sim_wp_lookup.sv
module sim_wp_lookup;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [11:0] req_addr = '0;
   logic       req_ready, busy, rsp_valid, rsp_hit, rsp_miss, rsp_slow;
   logic [1:0] data_sel, rsp_way;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // reference state of the bench, built from the requirements
   logic [7:0] m_tag [4][4];
   bit         m_val [4][4];
   int         m_pred [4];
   int         m_rr;

   always #5 clk = ~clk;

   wp_lookup u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_ready(req_ready), .busy(busy), .data_sel(data_sel),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss),
      .rsp_way(rsp_way), .rsp_slow(rsp_slow)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at a falling edge
   task automatic access(input logic [11:0] a, input string lbl);
      int s = int'(a[3:2]);
      logic [7:0] t = a[11:4];
      int m = -1;
      int kind;
      int way;
      string r;
      for (int w = 3; w >= 0; w--) if (m_val[s][w] && m_tag[s][w] == t) m = w;
      if (m >= 0 && m == m_pred[s]) begin kind = 0; way = m; r = "R3"; end
      else if (m >= 0) begin kind = 1; way = m; r = "R4"; end
      else begin
         kind = 2;
         way = -1;
         for (int w = 3; w >= 0; w--) if (!m_val[s][w]) way = w;
         if (way < 0) begin way = m_rr; m_rr = (m_rr + 1) % 4; r = "R7"; end
         else r = "R6";
         m_val[s][way] = 1'b1;
         m_tag[s][way] = t;
      end
      if (lbl != "") r = lbl;
      req_valid = 1'b1;
      req_addr  = a;
      #1;
      chk(data_sel == 2'(m_pred[s]), "R9", data_sel, m_pred[s]);
      m_pred[s] = way;
      @(negedge clk);
      if (kind == 0) begin
         chk({rsp_valid, rsp_hit, rsp_miss, rsp_slow, busy, rsp_way} == {5'b11000, 2'(way)},
             r, {rsp_valid, rsp_hit, rsp_miss, rsp_slow, busy, rsp_way}, {5'b11000, 2'(way)});
      end else begin
         chk({busy, req_ready, rsp_valid, data_sel} == {3'b100, 2'(way)}, r,
             {busy, req_ready, rsp_valid, data_sel}, {3'b100, 2'(way)});
         req_addr = a ^ 12'h530;   // offered while busy: must be dropped
         @(negedge clk);
         chk({rsp_valid, rsp_hit, rsp_miss, rsp_slow, busy, rsp_way} ==
             {1'b1, kind == 1, kind == 2, 2'b10, 2'(way)}, r,
             {rsp_valid, rsp_hit, rsp_miss, rsp_slow, busy, rsp_way},
             {1'b1, kind == 1, kind == 2, 2'b10, 2'(way)});
         req_valid = 1'b0;
         @(negedge clk);
         chk({rsp_valid, rsp_hit, rsp_miss} == 3'b000, "R8",
             {rsp_valid, rsp_hit, rsp_miss}, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] a;
      int seed = 12345;
      for (int s = 0; s < 4; s++) begin
         m_pred[s] = 0;
         for (int w = 0; w < 4; w++) begin m_val[s][w] = 1'b0; m_tag[s][w] = '0; end
      end
      m_rr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({req_ready, busy, rsp_valid} == 3'b100, "R1", {req_ready, busy, rsp_valid}, 3'b100);

      // fill every set past capacity
      for (int s = 0; s < 4; s++) begin
         for (int t = 0; t < 5; t++) begin
            a = {8'(t * 3 + 1), 2'(s), 2'(t % 4)};
            if (s == 0 && t == 0) access(a, "R1");
            else if (t == 0) access(a, "R10");
            else access(a, "");
         end
      end

      // revisit out of order, with offset changes
      for (int s = 3; s >= 0; s--) begin
         for (int t = 4; t >= 1; t--) begin
            a = {8'(t * 3 + 1), 2'(s), 2'(t % 4)};
            access(a, "");
            access({a[11:2], ~a[1:0]}, "R2");
            access(a, "R5");
         end
      end

      // pseudo-random mix over six tags per set
      for (int k = 0; k < 500; k++) begin
         seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
         a = {8'(((seed >> 8) % 6) * 5 + 2), 2'(seed >> 4), 2'(seed >> 2)};
         access(a, "");
      end

      req_valid = 1'b0;
      @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule